// File: doc/BRIEF.md
# NAND Flash Bus Sequencer

This block turns a one-request-at-a-time command interface into pin activity on an 8-bit parallel NAND flash bus. Each request asks for one action: a command byte, an address byte, a data write, a data read, or a change of chip selection. For each bus action the block raises the matching latch-enable pin and produces a write-enable or read-enable strobe whose low and high widths are set in clock cycles.

Chips form a linear array of equal-sized devices behind one flat address space. A select request takes its chip index from the upper bits of a linear address. The block first releases every chip-enable line and only then asserts the one line requested. After a command byte the block waits for the device to finish. It either polls the ready/busy line, with a timeout that raises an error flag, or, when no such line is wired, counts a fixed delay.

A request is taken only while `req_ready` is high. `done` pulses for one cycle when the action and any wait are complete.

Top module: `nand_bus_seq`

## Requirements
- R1: `nand_cle` is high only during the bus cycle of a command request (op code 0), and `nand_ale` is high only during the bus cycle of an address request (op code 1). The two are never high together, and both are low after reset.
- R2: For a command, address or write request (op codes 0, 1, 2), `nand_we_n` goes low for `cfg_lo` cycles and then high for `cfg_hi` cycles, with a value of 0 in either field acting as 1. The byte stays on `nand_dq_out` with `nand_dq_oe` high across both phases, so a chip latching on the rising edge of write-enable sees it. `done` follows one cycle after the high phase.
- R3: For a read request (op code 3), `nand_re_n` goes low for `cfg_lo` cycles and then high for `cfg_hi` cycles, with the bus not driven. `nand_dq_in` is captured in the last low cycle and is held on `rd_data` when `done` pulses.
- R4: A select request (op code 4) drives every `nand_ce_n` line high in the first cycle after acceptance. In the next cycle it drives low only line k, where k = `req_addr[ADDR_W-1:ADDR_W-IDX_W]`. `done` pulses in that second cycle, and at most one line is ever low.
- R5: A deselect request (op code 5), or a select whose index is not below NUM_CHIPS, leaves every `nand_ce_n` line high after the same two-cycle sequence.
- R6: `dev_ready` reports the ready/busy input, registered, with 1 meaning ready. With `cfg_use_rb`=1, a command request completes only after the registered ready/busy input reads 1. The first wait cycle is ignored.
- R7: With `cfg_use_rb`=0, a command request waits `cfg_delay` cycles after its strobe, so `done` comes lo+hi+delay+1 cycles after acceptance. A delay of 0 means no wait.
- R8: With `cfg_use_rb`=1, if the device stays busy for `cfg_timeout` wait cycles (0 acting as 1), the wait ends and `timeout_err` is set. The flag holds until the next request is accepted, which clears it.
- R9: `req_ready` is high only while idle. A request presented while busy has no effect on the bus and produces no `done`. `done` is a single-cycle pulse.
- R10: `nand_wp_n` is held high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request accepted this cycle if valid |
| req_op | input | 3 | 0 cmd, 1 addr, 2 write, 3 read, 4 select, 5 deselect, 6/7 no bus action |
| req_data | input | 8 | Byte for cmd, addr or write |
| req_addr | input | ADDR_W | Linear address; upper IDX_W bits give the chip index for select |
| cfg_lo | input | 4 | Strobe low width in cycles |
| cfg_hi | input | 4 | Strobe high width in cycles |
| cfg_use_rb | input | 1 | 1: poll ready/busy after a command; 0: fixed delay |
| cfg_delay | input | 16 | Post-command delay in cycles when not polling |
| cfg_timeout | input | 16 | Ready-wait limit in cycles |
| done | output | 1 | Request finished (one-cycle pulse) |
| rd_data | output | 8 | Byte captured by the last read |
| timeout_err | output | 1 | Last ready wait timed out |
| dev_ready | output | 1 | Registered ready/busy input, 1 = ready |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | NUM_CHIPS | Chip enables, active low |
| nand_we_n | output | 1 | Write enable strobe, active low |
| nand_re_n | output | 1 | Read enable strobe, active low |
| nand_wp_n | output | 1 | Write protect, held inactive (high) |
| nand_dq_out | output | 8 | Bus byte driven toward the chips |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus byte from the chips |
| nand_rb | input | 1 | Ready/busy line, low = busy |

## Verification
Commands run in delay mode with a non-zero and a zero delay, which separates the wait path from the direct path. Writes run with wide, minimal and zero-coded widths, which checks that 0 acts as 1. Reads use two bytes and two low widths, so a capture in the wrong cycle or from a stale value shows up. Select runs with three indices and a deselect, and every one checks the all-high break cycle. A ready/busy line released late and one held low check polling against timeout, and a follow-up request confirms that the error flag clears on acceptance.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    localparam int DQ_W  = 8;
    localparam int TMR_W = 16;

    typedef enum logic [2:0] {
        OP_CMD      = 3'd0,
        OP_ADDR     = 3'd1,
        OP_WRITE    = 3'd2,
        OP_READ     = 3'd3,
        OP_SELECT   = 3'd4,
        OP_DESELECT = 3'd5,
        OP_NOP6     = 3'd6,
        OP_NOP7     = 3'd7
    } nbs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_WAIT,
        ST_SEL,
        ST_FIN
    } nbs_state_e;

    typedef struct packed {
        nbs_op_e           op;
        logic [DQ_W-1:0]   data;
    } nbs_req_t;

    function automatic logic [TMR_W-1:0] nbs_min1(input logic [TMR_W-1:0] v);
        return (v == '0) ? TMR_W'(1) : v;
    endfunction

    function automatic logic nbs_is_bus(input nbs_op_e op);
        return (op == OP_CMD) || (op == OP_ADDR) || (op == OP_WRITE) || (op == OP_READ);
    endfunction

    function automatic logic nbs_is_sel(input nbs_op_e op);
        return (op == OP_SELECT) || (op == OP_DESELECT);
    endfunction

endpackage

// File: rtl/nbs_timer.sv
module nbs_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/nbs_ce_ctrl.sv
module nbs_ce_ctrl #(
    parameter int NUM_CHIPS = 4,
    parameter int IDX_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear_all,
    input  logic                 apply,
    input  logic                 none,
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_CHIPS-1:0] ce_n
);
    logic [NUM_CHIPS-1:0] pick;

    for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_pick
        assign pick[i] = !none && (idx == IDX_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst || clear_all) begin
            ce_n <= '1;
        end else if (apply) begin
            ce_n <= ~pick;
        end
    end

    AST_CE_ONE_LOW: assert property (@(posedge clk) disable iff (rst) $onehot0(~ce_n)); // R4
endmodule

// File: rtl/nbs_ready_wait.sv
module nbs_ready_wait
    import nbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             use_rb,
    input  logic [TMR_W-1:0] delay,
    input  logic [TMR_W-1:0] timeout,
    input  logic             rb_ok,
    output logic             finish,
    output logic             tmo
);
    logic             active;
    logic             use_rb_q;
    logic             settled;
    logic             expired;
    logic [TMR_W-1:0] load_val;

    assign load_val = use_rb ? (nbs_min1(timeout) - TMR_W'(1)) : (nbs_min1(delay) - TMR_W'(1));

    nbs_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (load_val),
        .expired  (expired)
    );

    logic seen_ready;
    assign seen_ready = use_rb_q && settled && rb_ok;
    assign finish     = active && (seen_ready || expired);
    assign tmo        = active && use_rb_q && expired && !seen_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            use_rb_q <= 1'b0;
            settled  <= 1'b0;
        end else if (start) begin
            active   <= 1'b1;
            use_rb_q <= use_rb;
            settled  <= 1'b0;
        end else if (active) begin
            settled <= 1'b1;
            if (finish) begin
                active <= 1'b0;
            end
        end
    end

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst) start |-> !active); // R9
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
    import nbs_pkg::*;
#(
    parameter int NUM_CHIPS = 4,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [2:0]           req_op,
    input  logic [7:0]           req_data,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [3:0]           cfg_lo,
    input  logic [3:0]           cfg_hi,
    input  logic                 cfg_use_rb,
    input  logic [15:0]          cfg_delay,
    input  logic [15:0]          cfg_timeout,
    output logic                 done,
    output logic [7:0]           rd_data,
    output logic                 timeout_err,
    output logic                 dev_ready,
    output logic                 nand_cle,
    output logic                 nand_ale,
    output logic [NUM_CHIPS-1:0] nand_ce_n,
    output logic                 nand_we_n,
    output logic                 nand_re_n,
    output logic                 nand_wp_n,
    output logic [7:0]           nand_dq_out,
    output logic                 nand_dq_oe,
    input  logic [7:0]           nand_dq_in,
    input  logic                 nand_rb
);
    localparam int IDX_W    = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1;
    localparam int CHIP_LSB = ADDR_W - IDX_W;

    nbs_state_e       state;
    nbs_req_t         req_r;
    nbs_op_e          op_in;
    logic             accept;
    logic             rb_q;
    logic [IDX_W-1:0] sel_idx_r;
    logic             sel_none_r;
    logic [ADDR_W-1:0] addr_shift;

    assign op_in      = nbs_op_e'(req_op);
    assign accept     = (state == ST_IDLE) && req_valid;
    assign addr_shift = req_addr >> CHIP_LSB;

    // strobe timing
    logic             st_load;
    logic [TMR_W-1:0] st_val;
    logic             st_exp;

    always_comb begin
        st_load = 1'b0;
        st_val  = '0;
        if (accept && nbs_is_bus(op_in)) begin
            st_load = 1'b1;
            st_val  = nbs_min1({12'd0, cfg_lo}) - TMR_W'(1);
        end else if ((state == ST_LO) && st_exp) begin
            st_load = 1'b1;
            st_val  = nbs_min1({12'd0, cfg_hi}) - TMR_W'(1);
        end
    end

    nbs_timer #(.W(TMR_W)) u_strobe_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (st_load),
        .load_val (st_val),
        .expired  (st_exp)
    );

    // post-command wait
    logic hi_end;
    logic need_wait;
    logic wait_start;
    logic wait_fin;
    logic wait_tmo;

    assign hi_end     = (state == ST_HI) && st_exp;
    assign need_wait  = (req_r.op == OP_CMD) && (cfg_use_rb || (cfg_delay != '0));
    assign wait_start = hi_end && need_wait;

    nbs_ready_wait u_wait (
        .clk     (clk),
        .rst     (rst),
        .start   (wait_start),
        .use_rb  (cfg_use_rb),
        .delay   (cfg_delay),
        .timeout (cfg_timeout),
        .rb_ok   (rb_q),
        .finish  (wait_fin),
        .tmo     (wait_tmo)
    );

    // chip enables
    nbs_ce_ctrl #(.NUM_CHIPS(NUM_CHIPS), .IDX_W(IDX_W)) u_ce (
        .clk       (clk),
        .rst       (rst),
        .clear_all (accept && nbs_is_sel(op_in)),
        .apply     (state == ST_SEL),
        .none      (sel_none_r),
        .idx       (sel_idx_r),
        .ce_n      (nand_ce_n)
    );

    // sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            req_r       <= '{op: OP_NOP6, data: '0};
            rd_data     <= '0;
            timeout_err <= 1'b0;
            sel_idx_r   <= '0;
            sel_none_r  <= 1'b1;
            rb_q        <= 1'b0;
        end else begin
            rb_q <= nand_rb;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_r.op    <= op_in;
                        req_r.data  <= req_data;
                        timeout_err <= 1'b0;
                        sel_idx_r   <= addr_shift[IDX_W-1:0];
                        sel_none_r  <= (op_in == OP_DESELECT) ||
                                       (addr_shift >= ADDR_W'(NUM_CHIPS));
                        if (nbs_is_bus(op_in)) begin
                            state <= ST_LO;
                        end else if (nbs_is_sel(op_in)) begin
                            state <= ST_SEL;
                        end else begin
                            state <= ST_FIN;
                        end
                    end
                end
                ST_LO: begin
                    if (st_exp) begin
                        state <= ST_HI;
                        if (req_r.op == OP_READ) begin
                            rd_data <= nand_dq_in;
                        end
                    end
                end
                ST_HI: begin
                    if (st_exp) begin
                        state <= need_wait ? ST_WAIT : ST_FIN;
                    end
                end
                ST_WAIT: begin
                    if (wait_tmo) begin
                        timeout_err <= 1'b1;
                    end
                    if (wait_fin) begin
                        state <= ST_FIN;
                    end
                end
                ST_SEL:  state <= ST_FIN;
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // pin drive
    logic bus_phase;
    assign bus_phase   = (state == ST_LO) || (state == ST_HI);
    assign nand_cle    = bus_phase && (req_r.op == OP_CMD);
    assign nand_ale    = bus_phase && (req_r.op == OP_ADDR);
    assign nand_we_n   = !((state == ST_LO) && (req_r.op != OP_READ));
    assign nand_re_n   = !((state == ST_LO) && (req_r.op == OP_READ));
    assign nand_dq_oe  = bus_phase && (req_r.op != OP_READ);
    assign nand_dq_out = req_r.data;
    assign nand_wp_n   = 1'b1;
    assign req_ready   = (state == ST_IDLE);
    assign done        = (state == ST_FIN);
    assign dev_ready   = rb_q;

    AST_LATCH_EXCL:  assert property (@(posedge clk) disable iff (rst) !(nand_cle && nand_ale)); // R1
    AST_CLE_DRIVEN:  assert property (@(posedge clk) disable iff (rst) nand_cle |-> nand_dq_oe); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(!nand_we_n && !nand_re_n)); // R2
    AST_RD_UNDRIVEN: assert property (@(posedge clk) disable iff (rst) !nand_re_n |-> !nand_dq_oe); // R3
    AST_SEL_BREAK:   assert property (@(posedge clk) disable iff (rst) (state == ST_SEL) |-> (nand_ce_n == '1)); // R4
    AST_BUSY_HOLD:   assert property (@(posedge clk) disable iff (rst) (state != ST_IDLE) |=> $stable(req_r)); // R9
    AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
    AST_ERR_CAUSE:   assert property (@(posedge clk) disable iff (rst) $rose(timeout_err) |-> $past(state == ST_WAIT)); // R8
endmodule

// File: tb/tb_nand_bus_seq.sv
`timescale 1ns/1ps
module tb_nand_bus_seq;
    localparam int NUM_CHIPS = 4;
    localparam int ADDR_W    = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [2:0]           req_op = '0;
    logic [7:0]           req_data = '0;
    logic [ADDR_W-1:0]    req_addr = '0;
    logic [3:0]           cfg_lo = 4'd1;
    logic [3:0]           cfg_hi = 4'd1;
    logic                 cfg_use_rb = 1'b0;
    logic [15:0]          cfg_delay = '0;
    logic [15:0]          cfg_timeout = 16'd10;
    logic                 done;
    logic [7:0]           rd_data;
    logic                 timeout_err;
    logic                 dev_ready;
    logic                 nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n, nand_dq_oe;
    logic [NUM_CHIPS-1:0] nand_ce_n;
    logic [7:0]           nand_dq_out;
    logic [7:0]           nand_dq_in = '0;
    logic                 nand_rb = 1'b1;

    nand_bus_seq #(.NUM_CHIPS(NUM_CHIPS), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_data(req_data), .req_addr(req_addr),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_use_rb(cfg_use_rb),
        .cfg_delay(cfg_delay), .cfg_timeout(cfg_timeout),
        .done(done), .rd_data(rd_data), .timeout_err(timeout_err), .dev_ready(dev_ready),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    typedef struct {
        int        lat;
        bit        exact;
        bit        chk_rd;
        logic [7:0] rd;
        bit        err;
        string     tag;
    } exp_t;

    typedef struct {
        bit         cle;
        bit         ale;
        logic [7:0] b;
        int         lo;
        string      tag;
    } latch_t;

    exp_t   sb_q[$];
    latch_t lt_q[$];

    int cyc       = 0;
    int cur_start = 0;
    int lowcnt    = 0;
    bit we_prev   = 1'b1;
    int rb_hold   = 0;
    int rb_cnt    = 0;
    bit rb_force_low = 1'b0;

    // monitor: scoreboard pops on done, latched bytes on write-enable rise, chip model for ready/busy
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    int lat;
                    e   = sb_q.pop_front();
                    lat = cyc - cur_start;
                    if (e.exact) check(lat == e.lat, e.tag, "latency", lat, e.lat);
                    else         check(lat >= e.lat, e.tag, "latency min", lat, e.lat);
                    if (e.chk_rd) check(rd_data == e.rd, e.tag, "rd_data", rd_data, e.rd);
                    check(timeout_err == e.err, e.tag, "timeout_err", timeout_err, e.err);
                end
            end
            if (!nand_we_n) lowcnt++;
            if (!we_prev && nand_we_n) begin
                if (lt_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected latch", nand_dq_out, 0);
                end else begin
                    latch_t l;
                    l = lt_q.pop_front();
                    check(nand_cle == l.cle, l.tag, "cle at latch", nand_cle, l.cle);
                    check(nand_ale == l.ale, l.tag, "ale at latch", nand_ale, l.ale);
                    check(nand_dq_oe && nand_dq_out == l.b, l.tag, "latched byte", nand_dq_out, l.b);
                    check(lowcnt == l.lo, l.tag, "we low width", lowcnt, l.lo);
                end
                if (nand_cle && rb_hold > 0) rb_cnt = rb_hold;
                lowcnt = 0;
            end
            we_prev = nand_we_n;
        end
        if (rb_cnt > 0) begin
            nand_rb = 1'b0;
            rb_cnt--;
        end else begin
            nand_rb = !rb_force_low;
        end
    end

    function automatic int min1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic handshake(input logic [2:0] op, input logic [7:0] d, input bit poke);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op    = op;
        req_data  = d;
        req_valid = 1'b1;
        @(posedge clk);
        cur_start = cyc;
        @(negedge clk);
        check(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
        if (poke) begin
            req_op   = 3'd0;
            req_data = 8'hEE;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] d, input int lat, input bit exact,
                         input bit chk_rd, input logic [7:0] rd, input bit err,
                         input string tag, input bit poke);
        exp_t e;
        e = '{lat: lat, exact: exact, chk_rd: chk_rd, rd: rd, err: err, tag: tag};
        sb_q.push_back(e);
        if (op <= 3'd2) begin
            latch_t l;
            l = '{cle: (op == 3'd0), ale: (op == 3'd1), b: d, lo: min1(int'(cfg_lo)), tag: tag};
            lt_q.push_back(l);
        end
        handshake(op, d, poke);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic select(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                          input logic [NUM_CHIPS-1:0] exp_ce, input string tag);
        exp_t e;
        e = '{lat: 2, exact: 1'b1, chk_rd: 1'b0, rd: 8'h00, err: 1'b0, tag: tag};
        sb_q.push_back(e);
        req_addr = a;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op    = op;
        req_valid = 1'b1;
        @(posedge clk);
        cur_start = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        check(nand_ce_n == '1, "R4", "all released first", nand_ce_n, 15);
        @(negedge clk);
        check(nand_ce_n == exp_ce, tag, "chip enables", nand_ce_n, exp_ce);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(negedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state
        check(nand_cle == 1'b0 && nand_ale == 1'b0, "R1", "latches after reset", {nand_cle, nand_ale}, 0);
        check(nand_we_n && nand_re_n, "R2", "strobes after reset", {nand_we_n, nand_re_n}, 3);
        check(nand_ce_n == '1, "R5", "ce after reset", nand_ce_n, 15);
        check(req_ready == 1'b1 && done == 1'b0, "R9", "idle after reset", {req_ready, done}, 2);
        check(nand_wp_n == 1'b1, "R10", "wp after reset", nand_wp_n, 1);

        // command with fixed delay
        cfg_use_rb = 1'b0; cfg_lo = 4'd2; cfg_hi = 4'd1; cfg_delay = 16'd4;
        issue(3'd0, 8'h70, 8, 1'b1, 1'b0, 8'h00, 1'b0, "R7", 1'b0);
        cfg_delay = 16'd0;
        issue(3'd0, 8'hFF, 4, 1'b1, 1'b0, 8'h00, 1'b0, "R7", 1'b0);

        // address and write strobes
        cfg_lo = 4'd2; cfg_hi = 4'd2;
        issue(3'd1, 8'h3A, 5, 1'b1, 1'b0, 8'h00, 1'b0, "R1", 1'b0);
        cfg_lo = 4'd3; cfg_hi = 4'd2;
        issue(3'd2, 8'hC4, 6, 1'b1, 1'b0, 8'h00, 1'b0, "R2", 1'b1);
        cfg_lo = 4'd0; cfg_hi = 4'd0;
        issue(3'd2, 8'h5B, 3, 1'b1, 1'b0, 8'h00, 1'b0, "R2", 1'b0);

        // reads
        cfg_lo = 4'd2; cfg_hi = 4'd1; nand_dq_in = 8'hA5;
        issue(3'd3, 8'h00, 4, 1'b1, 1'b1, 8'hA5, 1'b0, "R3", 1'b0);
        cfg_lo = 4'd4; cfg_hi = 4'd3; nand_dq_in = 8'h3C;
        issue(3'd3, 8'h00, 8, 1'b1, 1'b1, 8'h3C, 1'b0, "R3", 1'b0);

        // chip selection
        select(3'd4, {2'b10, 10'h155}, 4'b1011, "R4");
        select(3'd4, {2'b00, 10'h3FF}, 4'b1110, "R4");
        select(3'd4, {2'b11, 10'h000}, 4'b0111, "R4");
        select(3'd5, {2'b01, 10'h001}, 4'b1111, "R5");

        // ready/busy reporting
        rb_force_low = 1'b1;
        repeat (2) @(negedge clk);
        check(dev_ready == 1'b0, "R6", "dev_ready busy", dev_ready, 0);
        rb_force_low = 1'b0;
        repeat (2) @(negedge clk);
        check(dev_ready == 1'b1, "R6", "dev_ready ready", dev_ready, 1);

        // polled wait, released after 6 cycles
        cfg_use_rb = 1'b1; cfg_lo = 4'd1; cfg_hi = 4'd1; cfg_timeout = 16'd100; rb_hold = 6;
        issue(3'd0, 8'h10, 8, 1'b0, 1'b0, 8'h00, 1'b0, "R6", 1'b0);
        rb_hold = 0;

        // timeout with line held busy
        rb_force_low = 1'b1; cfg_timeout = 16'd5;
        repeat (2) @(negedge clk);
        issue(3'd0, 8'h60, 8, 1'b1, 1'b0, 8'h00, 1'b1, "R8", 1'b0);
        check(timeout_err == 1'b1, "R8", "flag held while idle", timeout_err, 1);
        rb_force_low = 1'b0;
        issue(3'd1, 8'h01, 3, 1'b1, 1'b0, 8'h00, 1'b0, "R8", 1'b0);

        repeat (3) @(negedge clk);
        check(nand_wp_n == 1'b1, "R10", "wp at end", nand_wp_n, 1);
        check(lt_q.size() == 0, "R9", "pending latches", lt_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule